// File: doc/BRIEF.md
# Bus-Mapped GPIO Controller with Pin Interrupts

This block is a general-purpose I/O peripheral that sits on an APB-style register bus. It provides up to four ports. Each port has a register that holds the output value, a register that chooses which pins drive, and a read-only view of the pin levels after synchronisation. Software reads and writes these through ordinary bus transfers.

The first port also has an interrupt unit. Each of its pins can be enabled, masked, and set to be either level-sensitive or edge-sensitive with a chosen polarity. Edge events are latched and then cleared by a write-one-to-clear register. Level events track the pin directly. All unmasked, enabled status bits are combined into one interrupt output.

A write takes effect at the clock edge that ends the access phase (`psel`, `penable` and `pwrite` all high). Read data is combinational during the access phase. The bus has no wait states and no error response. Pins pass through a two-flop synchroniser before they are read back or examined for edges.

Top module: `gpio_apb_top`

## Requirements
- R1: Port i keeps an output register at byte offset 12*i and a drive-enable register at 12*i+4 (0x00/0x04, 0x0c/0x10, 0x18/0x1c, 0x24/0x28). Both registers read back what was written, drive `pin_out` and `pin_oe` at bit positions i*PORT_W upward, and reset to zero.
- R2: The synchronised level of the pins of port i reads at offset 0x50+4*i. A pin change is visible there two clock edges later.
- R3: The registers of the port A interrupt unit read back as written: enable at 0x30, mask at 0x34, type at 0x38 and polarity at 0x3c. The clear register at 0x4c always reads zero.
- R4: A pin whose type bit is 1 is edge-sensitive. Its polarity bit selects the edge: 1 for rising, 0 for falling. A qualifying edge latches a status bit only while that pin's enable bit is 1. Clearing the enable bit discards the latched bit.
- R5: A pin whose type bit is 0 is level-sensitive. Its status is active while the synchronised pin equals its polarity bit (1 = active-high, 0 = active-low). Writes to 0x4c do not affect it.
- R6: Writing 1 to a bit of 0x4c clears that pin's latched edge, and writing 0 leaves it unchanged. If an edge and a clear of the same pin fall in the same cycle, the bit stays set.
- R7: A mask bit of 1 hides that pin from the status register (0x40) and from `irq` without discarding its latched edge. A mask bit of 0 lets it through.
- R8: `irq` is high exactly when the status register at 0x40 is non-zero.
- R9: Only port A can interrupt. Pin activity on the other ports never changes the status register or `irq`.
- R10: Addresses that are not mapped read as zero. After reset, `irq` is low and the status register is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 7 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| pin_in | input | NUM_PORTS*PORT_W | External pin levels, asynchronous |
| pin_out | output | NUM_PORTS*PORT_W | Output values for the pins |
| pin_oe | output | NUM_PORTS*PORT_W | Per-pin drive enable |
| irq | output | 1 | Combined interrupt |

## Verification
The bench times an edge so that it lands in the same cycle as its own end-of-interrupt write. A design that gives the clear priority would lose that event. Masking is tested while an edge is latched, so a design that drops the latch under the mask would show nothing after unmasking. An edge on a disabled pin, followed later by enabling that pin, must not show up; a design that latches regardless of enable would fire late. The bench also checks that end-of-interrupt writes leave level status alone, and that toggling the port B pins leaves the interrupt untouched.

// File: rtl/gpio_apb_pkg.sv
package gpio_apb_pkg;
  localparam int ADDR_W    = 7;
  localparam int DATA_W    = 32;
  localparam int MAX_PORTS = 4;

  localparam logic [ADDR_W-1:0] A_IRQ_EN   = 7'h30;
  localparam logic [ADDR_W-1:0] A_IRQ_MSK  = 7'h34;
  localparam logic [ADDR_W-1:0] A_IRQ_TYP  = 7'h38;
  localparam logic [ADDR_W-1:0] A_IRQ_POL  = 7'h3c;
  localparam logic [ADDR_W-1:0] A_IRQ_STS  = 7'h40;
  localparam logic [ADDR_W-1:0] A_IRQ_CLR  = 7'h4c;
  localparam logic [ADDR_W-1:0] A_PIN_BASE = 7'h50;

  function automatic logic [ADDR_W-1:0] out_ofs(input int idx);
    return ADDR_W'(idx * 12);
  endfunction

  function automatic logic [ADDR_W-1:0] dir_ofs(input int idx);
    return ADDR_W'(idx * 12 + 4);
  endfunction

  function automatic logic [ADDR_W-1:0] pin_ofs(input int idx);
    return ADDR_W'(32'h50 + idx * 4);
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      sync_o <= '0;
    end else begin
      stage1 <= async_i;
      sync_o <= stage1;
    end
  end
endmodule

// File: rtl/gpio_port_bank.sv
module gpio_port_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_out,
  input  logic         we_dir,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] out_q,
  output logic [W-1:0] dir_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      dir_q <= '0;
    end else begin
      if (we_out) out_q <= wdata;
      if (we_dir) dir_q <= wdata;
    end
  end
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_s,
  input  logic         we_en,
  input  logic         we_msk,
  input  logic         we_typ,
  input  logic         we_pol,
  input  logic         we_clr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] en_q,
  output logic [W-1:0] msk_q,
  output logic [W-1:0] typ_q,
  output logic [W-1:0] pol_q,
  output logic [W-1:0] status_o
);
  logic [W-1:0] prev_q;
  logic [W-1:0] latch_q;
  logic [W-1:0] hit;
  logic [W-1:0] clr_bits;
  logic [W-1:0] level_act;

  always_comb begin
    hit       = typ_q & en_q & ((pol_q & pin_s & ~prev_q) | (~pol_q & ~pin_s & prev_q));
    clr_bits  = we_clr ? wdata : '0;
    level_act = ~(pin_s ^ pol_q);
    status_o  = ((typ_q & latch_q) | (~typ_q & level_act)) & en_q & ~msk_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      msk_q   <= '0;
      typ_q   <= '0;
      pol_q   <= '0;
      prev_q  <= '0;
      latch_q <= '0;
    end else begin
      if (we_en)  en_q  <= wdata;
      if (we_msk) msk_q <= wdata;
      if (we_typ) typ_q <= wdata;
      if (we_pol) pol_q <= wdata;
      prev_q  <= pin_s;
      latch_q <= ((latch_q & ~clr_bits) | hit) & en_q;
    end
  end

  AST_EDGE_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit) |=> ((latch_q & $past(hit)) == $past(hit))); // R6
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    we_clr |=> ((latch_q & $past(wdata & ~hit)) == '0)); // R6
  AST_NO_LATCH_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((latch_q & ~$past(en_q)) == '0)); // R4
endmodule

// File: rtl/gpio_apb_top.sv
module gpio_apb_top
  import gpio_apb_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int PORT_W    = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          psel,
  input  logic                          penable,
  input  logic                          pwrite,
  input  logic [6:0]                    paddr,
  input  logic [31:0]                   pwdata,
  output logic [31:0]                   prdata,
  input  logic [NUM_PORTS*PORT_W-1:0]   pin_in,
  output logic [NUM_PORTS*PORT_W-1:0]   pin_out,
  output logic [NUM_PORTS*PORT_W-1:0]   pin_oe,
  output logic                          irq
);
  localparam int PIN_W = NUM_PORTS * PORT_W;

  logic              wr;
  logic [PIN_W-1:0]  pin_s;
  logic [PORT_W-1:0] out_q [NUM_PORTS];
  logic [PORT_W-1:0] dir_q [NUM_PORTS];
  logic [PORT_W-1:0] wdat;
  logic [PORT_W-1:0] en_q, msk_q, typ_q, pol_q, status;

  assign wr   = psel & penable & pwrite;
  assign wdat = pwdata[PORT_W-1:0];

  gpio_sync #(.W(PIN_W)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(pin_in), .sync_o(pin_s)
  );

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
    gpio_port_bank #(.W(PORT_W)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .we_out(wr && paddr == out_ofs(i)),
      .we_dir(wr && paddr == dir_ofs(i)),
      .wdata(wdat),
      .out_q(out_q[i]),
      .dir_q(dir_q[i])
    );
    assign pin_out[i*PORT_W +: PORT_W] = out_q[i];
    assign pin_oe[i*PORT_W +: PORT_W]  = dir_q[i];
  end

  gpio_irq_unit #(.W(PORT_W)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .pin_s(pin_s[PORT_W-1:0]),
    .we_en(wr && paddr == A_IRQ_EN),
    .we_msk(wr && paddr == A_IRQ_MSK),
    .we_typ(wr && paddr == A_IRQ_TYP),
    .we_pol(wr && paddr == A_IRQ_POL),
    .we_clr(wr && paddr == A_IRQ_CLR),
    .wdata(wdat),
    .en_q(en_q), .msk_q(msk_q), .typ_q(typ_q), .pol_q(pol_q),
    .status_o(status)
  );

  assign irq = |status;

  always_comb begin
    prdata = '0;
    if (psel) begin
      unique case (paddr)
        A_IRQ_EN:  prdata = 32'(en_q);
        A_IRQ_MSK: prdata = 32'(msk_q);
        A_IRQ_TYP: prdata = 32'(typ_q);
        A_IRQ_POL: prdata = 32'(pol_q);
        A_IRQ_STS: prdata = 32'(status);
        default:   prdata = '0;
      endcase
      for (int i = 0; i < NUM_PORTS; i++) begin
        if (paddr == out_ofs(i)) prdata = 32'(out_q[i]);
        if (paddr == dir_ofs(i)) prdata = 32'(dir_q[i]);
        if (paddr == pin_ofs(i)) prdata = 32'(pin_s[i*PORT_W +: PORT_W]);
      end
    end
  end

  AST_OUT_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && paddr == 7'h00) |=> (pin_out[PORT_W-1:0] == $past(wdat))); // R1
  AST_DIR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && paddr == 7'h04) |=> $stable(pin_oe[PORT_W-1:0])); // R1
endmodule

// File: tb/sim_gpio_apb_top.sv
module sim_gpio_apb_top;
  localparam int NP = 4;
  localparam int PW = 32;

  logic clk = 0;
  logic rst_n = 0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [6:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic [NP*PW-1:0] pin_in = '0;
  logic [NP*PW-1:0] pin_out, pin_oe;
  logic irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gpio_apb_top #(.NUM_PORTS(NP), .PORT_W(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  // {type, polarity, pin before, pin after, expected status bit 0}
  localparam logic [4:0] VEC [9] = '{
    5'b11011, 5'b11100, 5'b10101, 5'b10010,
    5'b01111, 5'b01000, 5'b00001, 5'b00110, 5'b11000
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk); penable = 1; #1 d = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    idle(3); rst_n = 1; idle(1);

    // R10 reset state
    rd(7'h40, d); check("R10 status after reset", d, 0);
    check("R10 irq after reset", {31'd0, irq}, 0);
    rd(7'h00, d); check("R1 out reg reset", d, 0);
    check("R1 pin_oe reset", pin_oe[31:0], 0);
    rd(7'h44, d); check("R10 unmapped read", d, 0);

    // R1 per-port registers
    for (int i = 0; i < NP; i++) begin
      wr(7'(12*i), 32'h1357_0000 + i);
      wr(7'(12*i+4), 32'hF0F0_0000 + i);
    end
    for (int i = 0; i < NP; i++) begin
      rd(7'(12*i), d);   check("R1 out readback", d, 32'h1357_0000 + i);
      rd(7'(12*i+4), d); check("R1 dir readback", d, 32'hF0F0_0000 + i);
      check("R1 pin_out", pin_out[i*PW +: PW], 32'h1357_0000 + i);
      check("R1 pin_oe", pin_oe[i*PW +: PW], 32'hF0F0_0000 + i);
    end

    // R2 pin readback, port C
    pin_in[2*PW +: PW] = 32'hA5A5_0F0F; idle(3);
    rd(7'h58, d); check("R2 port C pins", d, 32'hA5A5_0F0F);
    pin_in = '0; idle(3);

    // R3 interrupt register readback
    wr(7'h34, 32'h0000_FF00); rd(7'h34, d); check("R3 mask", d, 32'h0000_FF00);
    wr(7'h3c, 32'h1234_5678); rd(7'h3c, d); check("R3 polarity", d, 32'h1234_5678);
    wr(7'h38, 32'hCAFE_0001); rd(7'h38, d); check("R3 type", d, 32'hCAFE_0001);
    wr(7'h30, 32'h0000_0000); rd(7'h30, d); check("R3 enable", d, 0);
    rd(7'h4c, d); check("R3 clear reads zero", d, 0);

    // R4 R5 table on pin 0
    wr(7'h34, 0); wr(7'h30, 32'h1);
    foreach (VEC[k]) begin
      wr(7'h38, {31'd0, VEC[k][4]});
      wr(7'h3c, {31'd0, VEC[k][3]});
      pin_in[0] = VEC[k][2]; idle(4);
      wr(7'h4c, 32'hFFFF_FFFF);
      pin_in[0] = VEC[k][1]; idle(4);
      rd(7'h40, d);
      check("R4 R5 table status", d, {31'd0, VEC[k][0]});
      check("R8 table irq", {31'd0, irq}, {31'd0, VEC[k][0]});
    end

    // R7 mask keeps latch; R6 clear behaviour, pin 3 rising edge
    pin_in = '0; wr(7'h30, 0); wr(7'h38, 32'h8); wr(7'h3c, 32'h8);
    wr(7'h34, 32'h8); wr(7'h30, 32'h8); idle(2);
    pin_in[3] = 1; idle(4);
    rd(7'h40, d); check("R7 masked status", d, 0);
    check("R7 masked irq", {31'd0, irq}, 0);
    wr(7'h34, 0);
    rd(7'h40, d); check("R7 unmasked status", d, 32'h8);
    check("R8 irq high", {31'd0, irq}, 1);
    wr(7'h4c, 32'h0); rd(7'h40, d); check("R6 zero write keeps", d, 32'h8);
    wr(7'h4c, 32'h8); rd(7'h40, d); check("R6 one write clears", d, 0);
    check("R8 irq low", {31'd0, irq}, 0);

    // R6 edge in the same cycle as its clear
    pin_in[3] = 0; idle(4);
    wr(7'h3c, 32'h0);          // falling edges on pin 3
    pin_in[3] = 1; idle(4);
    pin_in[3] = 0; @(negedge clk);
    wr(7'h4c, 32'h8);          // commit edge coincides with latch edge
    idle(1); rd(7'h40, d); check("R6 edge beats clear", d, 32'h8);
    wr(7'h4c, 32'h8);

    // R5 clear does not touch level status, pin 5 active-high
    wr(7'h38, 0); wr(7'h3c, 32'h20); wr(7'h30, 32'h20);
    pin_in[5] = 1; idle(4);
    wr(7'h4c, 32'h20); rd(7'h40, d); check("R5 level ignores clear", d, 32'h20);
    pin_in[5] = 0; idle(4);
    rd(7'h40, d); check("R5 level follows pin", d, 0);

    // R4 disabled pin latches nothing
    wr(7'h30, 0); wr(7'h38, 32'h80); wr(7'h3c, 32'h80); idle(1);
    pin_in[7] = 1; idle(4);
    wr(7'h30, 32'h80); rd(7'h40, d); check("R4 no latch while disabled", d, 0);
    pin_in[7] = 0; idle(3);

    // R9 other ports never interrupt
    wr(7'h30, 32'hFFFF_FFFF); wr(7'h38, 32'hFFFF_FFFF); wr(7'h3c, 32'hFFFF_FFFF);
    wr(7'h34, 0); wr(7'h4c, 32'hFFFF_FFFF);
    pin_in[PW +: 3*PW] = '1; idle(4);
    pin_in[PW +: 3*PW] = '0; idle(4);
    rd(7'h40, d); check("R9 status unaffected", d, 0);
    check("R9 irq unaffected", {31'd0, irq}, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule